// File: doc/BRIEF.md
# Complex Accumulator Load/Store Unit

This unit runs a small group of 16-bit load and store instructions for a complex-valued signal-processing datapath. It owns a complex accumulator, with a 32-bit real half and a 32-bit imaginary half, and four 32-bit control registers: a parameter register, a repeat register, an address base register and an X vector pointer. Each instruction makes at most one access to a synchronous 32-bit memory. Its result is then posted with a one-cycle done pulse and two error flags.

A controller offers an instruction when `instr_ready` is high. The unit decodes it, makes the single memory access, and updates the target register from the returned data. A store drives the write data instead. Unknown opcodes finish at once with an error and touch neither memory nor state. Register loads that break their format rule also finish with an error and leave the target unchanged. The accumulator can only be written by the two accumulator loads.

Top module: `cplx_ldst_unit`

## Requirements
- R1: The instruction's bits 15..11 are the opcode and bits 10..0 the memory address. The accepted opcodes are 00000 (load parameter), 00101 (load accumulator), 00110 (load repeat), 00111 (load address base), 01000 (load X), 01010 (store X), 10000 (extended accumulator load) and 11100 (store X lower). Any other opcode finishes with `done` and `err_illegal` high one cycle after acceptance, makes no memory request and changes no register.
- R2: Load accumulator takes the real part from memory bits 15..0 and the imaginary part from bits 31..16. Each part goes to bits 30..15 of its accumulator half, and bit 31 copies the part's bit 15.
- R3: On load accumulator, bit 14 of both halves equals the parameter register's rounding flag (bit 31), and bits 13..0 are zero.
- R4: Extended accumulator load writes memory bits 31..1 into bits 30..0 of both accumulator halves, with bit 31 equal to memory bit 31.
- R5: Load parameter stores the word only when its length field (bits 15..0) is nonzero. A zero length sets `err_format` and keeps the old value. The accumulator is unchanged either way.
- R6: Load address base stores the word only when its bits 16..0 are all zero. Otherwise it sets `err_format` and keeps the old value. The accumulator is unchanged.
- R7: Load repeat stores the whole word with no format check and leaves the accumulator unchanged.
- R8: Store X writes all 32 bits of X to the addressed word, with `mem_be` = 11 and `mem_we` high.
- R9: Store X lower writes X bits 15..0 to the low half of the word, with `mem_be` = 01 and bits 31..16 of `mem_wdata` at zero. Stores change no register.
- R10: A memory instruction raises `mem_req` for exactly one cycle, starting one cycle after acceptance. `done` follows two cycles after that request cycle. `instr_ready` is low from acceptance until `done`, and instructions offered while it is low are ignored.
- R11: After reset all registers and both accumulator halves are zero, `instr_ready` is high, and `done`, `mem_req` and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr | input | 16 | Opcode (15..11) and address (10..0) |
| instr_ready | output | 1 | Unit idle, instruction will be taken |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 2 | Half-word write enables (bit 0 = bits 15..0) |
| mem_addr | output | 11 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| err_illegal | output | 1 | Last instruction had an unknown opcode |
| err_format | output | 1 | Last register load was rejected |
| acc_re | output | 32 | Accumulator real half |
| acc_im | output | 32 | Accumulator imaginary half |
| param_q | output | 32 | Parameter register |
| repeat_q | output | 32 | Repeat register |
| base_q | output | 32 | Address base register |
| x_q | output | 32 | X vector pointer |

## Verification
The bench loads accumulator values with the sign bit set and clear, both before and after the rounding flag changes. A unit that took the wrong part, dropped the sign copy or ignored the flag would show a wrong real or imaginary half. It sends a zero-length parameter word and an address base word with bit 16 set, to catch a unit that stores bad formats or misses the error. It sends an unknown opcode, to catch a memory request or a missing error. It also offers an instruction while the unit is busy; a unit that accepted it would run that instruction and raise an error. Store tests catch a wrong half-enable or a lower store that leaks the upper bits.

// File: rtl/cplx_ldst_pkg.sv
// Shared opcodes, decode record and register field positions for the
// complex accumulator load/store unit. Assumes a 5-bit opcode field.
package cplx_ldst_pkg;
    localparam int OP_W    = 5;
    localparam int RND_POS = 31;  // rounding flag in parameter register
    localparam int LEN_W   = 16;  // length field, bits LEN_W-1..0
    localparam int BASE_ZW = 17;  // low bits of base that must be zero

    typedef enum logic [OP_W-1:0] {
        OP_LPARAM = 5'b00000,
        OP_LACC   = 5'b00101,
        OP_LREP   = 5'b00110,
        OP_LBASE  = 5'b00111,
        OP_LDX    = 5'b01000,
        OP_STX    = 5'b01010,
        OP_LEXT   = 5'b10000,
        OP_STXL   = 5'b11100
    } op_e;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_ACC, TGT_EXT, TGT_PARAM, TGT_REP, TGT_BASE, TGT_X
    } tgt_e;

    typedef struct packed {
        logic legal;
        logic store;
        logic half;
        tgt_e tgt;
    } dec_t;
endpackage

// File: rtl/ldst_decode.sv
// Opcode decoder: maps a 5-bit opcode to legality, store kind and the
// register it targets. Purely combinational; assumes nothing about timing.
module ldst_decode
    import cplx_ldst_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output dec_t            dec
);
    // Translate the opcode into a decode record; unknown codes are illegal.
    always_comb begin
        dec = '{legal: 1'b1, store: 1'b0, half: 1'b0, tgt: TGT_NONE};
        case (op_e'(opcode))
            OP_LPARAM: dec.tgt = TGT_PARAM;
            OP_LACC:   dec.tgt = TGT_ACC;
            OP_LREP:   dec.tgt = TGT_REP;
            OP_LBASE:  dec.tgt = TGT_BASE;
            OP_LDX:    dec.tgt = TGT_X;
            OP_LEXT:   dec.tgt = TGT_EXT;
            OP_STX:    dec.store = 1'b1;
            OP_STXL: begin
                dec.store = 1'b1;
                dec.half  = 1'b1;
            end
            default:   dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldst_acc_fmt.sv
// Builds the accumulator images for both halves from a memory word.
// Normal mode: part 0 (low half) feeds the real side, part 1 the imaginary
// side, each placed at bits 30..15 with sign copy and rounding bit.
// Extended mode: the word shifted right by one, sign-filled, feeds both.
module ldst_acc_fmt #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic              rnd,
    input  logic              ext,
    output logic [DATA_W-1:0] img_re,
    output logic [DATA_W-1:0] img_im
);
    localparam int HW = DATA_W / 2;

    logic [DATA_W-1:0] img [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HW-1:0] part;
        assign part   = rdata[h*HW +: HW];
        // Select extended or placed image for this half.
        assign img[h] = ext ? {rdata[DATA_W-1], rdata[DATA_W-1:1]}
                            : {part[HW-1], part, rnd, {(HW-2){1'b0}}};
    end

    assign img_re = img[0];
    assign img_im = img[1];
endmodule

// File: rtl/ldst_regs.sv
// Register bank: accumulator halves, parameter, repeat, base and X.
// Updates one target per completed load and applies the format rules for
// parameter and base loads. Assumes upd is a single-cycle strobe.
module ldst_regs
    import cplx_ldst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] img_re,
    input  logic [DATA_W-1:0] img_im,
    output logic              fmt_bad,
    output logic              rnd,
    output logic [DATA_W-1:0] acc_re,
    output logic [DATA_W-1:0] acc_im,
    output logic [DATA_W-1:0] param_q,
    output logic [DATA_W-1:0] repeat_q,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] x_q
);
    logic len_ok;
    logic base_ok;

    // Format rules for the checked register loads.
    always_comb begin
        len_ok  = |rdata[LEN_W-1:0];
        base_ok = ~|rdata[BASE_ZW-1:0];
        fmt_bad = ((tgt == TGT_PARAM) && !len_ok) ||
                  ((tgt == TGT_BASE)  && !base_ok);
    end

    assign rnd = param_q[RND_POS];

    // Write the targeted register when a load completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_re   <= '0;
            acc_im   <= '0;
            param_q  <= '0;
            repeat_q <= '0;
            base_q   <= '0;
            x_q      <= '0;
        end else if (upd) begin
            case (tgt)
                TGT_ACC, TGT_EXT: begin
                    acc_re <= img_re;
                    acc_im <= img_im;
                end
                TGT_PARAM: if (len_ok)  param_q <= rdata;
                TGT_BASE:  if (base_ok) base_q  <= rdata;
                TGT_REP:   repeat_q <= rdata;
                TGT_X:     x_q      <= rdata;
                default:   ;
            endcase
        end
    end

    // R5/R6/R7: control register loads never disturb the accumulator.
    a_r5_acc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (tgt == TGT_PARAM || tgt == TGT_REP || tgt == TGT_BASE))
        |=> ($stable(acc_re) && $stable(acc_im)));

    // R6: a base value with nonzero low bits is never held.
    a_r6_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[BASE_ZW-1:0] == '0);

    // R2/R4: bit 31 of each half always copies bit 30.
    a_r2_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_re[DATA_W-1] == acc_re[DATA_W-2]) &&
        (acc_im[DATA_W-1] == acc_im[DATA_W-2]));
endmodule

// File: rtl/cplx_ldst_unit.sv
// Top of the complex accumulator load/store unit. A three-state sequencer
// (idle, access, response) takes one instruction at a time, makes one
// memory access, updates the register bank and pulses done. Assumes the
// memory returns read data the cycle after the request.
module cplx_ldst_unit
    import cplx_ldst_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   instr_valid,
    input  logic [OP_W+ADDR_W-1:0] instr,
    output logic                   instr_ready,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [1:0]             mem_be,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   done,
    output logic                   err_illegal,
    output logic                   err_format,
    output logic [DATA_W-1:0]      acc_re,
    output logic [DATA_W-1:0]      acc_im,
    output logic [DATA_W-1:0]      param_q,
    output logic [DATA_W-1:0]      repeat_q,
    output logic [DATA_W-1:0]      base_q,
    output logic [DATA_W-1:0]      x_q
);
    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int HW      = DATA_W / 2;

    typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_RSP} st_e;

    st_e               st;
    dec_t              dec_in;
    dec_t              dec_q;
    logic [ADDR_W-1:0] addr_q;
    logic              fmt_bad;
    logic              rnd;
    logic              upd;
    logic              take;
    logic [DATA_W-1:0] img_re;
    logic [DATA_W-1:0] img_im;

    ldst_decode u_dec (
        .opcode (instr[INSTR_W-1:ADDR_W]),
        .dec    (dec_in)
    );

    ldst_acc_fmt #(.DATA_W(DATA_W)) u_fmt (
        .rdata  (mem_rdata),
        .rnd    (rnd),
        .ext    (dec_q.tgt == TGT_EXT),
        .img_re (img_re),
        .img_im (img_im)
    );

    ldst_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .tgt      (dec_q.tgt),
        .rdata    (mem_rdata),
        .img_re   (img_re),
        .img_im   (img_im),
        .fmt_bad  (fmt_bad),
        .rnd      (rnd),
        .acc_re   (acc_re),
        .acc_im   (acc_im),
        .param_q  (param_q),
        .repeat_q (repeat_q),
        .base_q   (base_q),
        .x_q      (x_q)
    );

    // Handshake and register-update strobes.
    always_comb begin
        instr_ready = (st == ST_IDLE);
        take        = instr_ready && instr_valid;
        upd         = (st == ST_RSP) && !dec_q.store;
    end

    // Memory port driven during the access state only.
    always_comb begin
        mem_req   = (st == ST_ACC);
        mem_we    = mem_req && dec_q.store;
        mem_be    = dec_q.half ? 2'b01 : 2'b11;
        mem_addr  = addr_q;
        mem_wdata = dec_q.half ? {{HW{1'b0}}, x_q[HW-1:0]} : x_q;
    end

    // Sequencer: accept, access, respond; post done and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            dec_q       <= '{legal: 1'b0, store: 1'b0, half: 1'b0, tgt: TGT_NONE};
            addr_q      <= '0;
            done        <= 1'b0;
            err_illegal <= 1'b0;
            err_format  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (take) begin
                    addr_q <= instr[ADDR_W-1:0];
                    dec_q  <= dec_in;
                    if (!dec_in.legal) begin
                        done        <= 1'b1;
                        err_illegal <= 1'b1;
                        err_format  <= 1'b0;
                    end else begin
                        st <= ST_ACC;
                    end
                end
                ST_ACC: st <= ST_RSP;
                ST_RSP: begin
                    st          <= ST_IDLE;
                    done        <= 1'b1;
                    err_illegal <= 1'b0;
                    err_format  <= fmt_bad;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10: one access per instruction, never two cycles in a row.
    a_r10_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10: completion is only posted while the unit is idle again.
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> instr_ready);

    // R1: an unknown opcode finishes next cycle with no memory request.
    a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !dec_in.legal) |=> (done && err_illegal && !mem_req));

    // R9: a lower-half store never drives the upper data bits.
    a_r9_half_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == 2'b01) |-> (mem_wdata[DATA_W-1:HW] == '0));

    // R5/R6: a rejected load leaves both checked registers as they were.
    a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_format) |-> ($stable(param_q) && $stable(base_q)));
endmodule

// File: tb/cplx_ldst_unit_bench.sv
module cplx_ldst_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] mem_rdata = '0;
    logic        instr_ready, mem_req, mem_we, done, err_illegal, err_format;
    logic [1:0]  mem_be;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata, acc_re, acc_im, param_q, repeat_q, base_q, x_q;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cplx_ldst_unit u_cplx_ldst_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .instr_ready(instr_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .err_illegal(err_illegal),
        .err_format(err_format), .acc_re(acc_re), .acc_im(acc_im),
        .param_q(param_q), .repeat_q(repeat_q), .base_q(base_q), .x_q(x_q)
    );

    typedef struct packed {
        logic [15:0] ins;
        logic [31:0] rd;
        logic [31:0] re;
        logic [31:0] im;
        logic [31:0] par;
        logic [31:0] bas;
        logic        ill;
        logic        fmt;
    } vec_t;

    // Opcode in bits 15..11: LA=00101 (0x28xx), LPARAM=00000, LEA=10000,
    // LEABR=00111 (0x38xx), unknown 00001 (0x08xx).
    localparam vec_t VEC [11] = '{
        '{16'h2805, 32'h8001_1234, 32'h091A_0000, 32'hC000_8000, 32'h0, 32'h0, 1'b0, 1'b0}, // R2
        '{16'h0011, 32'h8000_0010, 32'h091A_0000, 32'hC000_8000, 32'h8000_0010, 32'h0, 1'b0, 1'b0}, // R5
        '{16'h2822, 32'h7FFF_FFFF, 32'hFFFF_C000, 32'h3FFF_C000, 32'h8000_0010, 32'h0, 1'b0, 1'b0}, // R3
        '{16'h0033, 32'h8000_0000, 32'hFFFF_C000, 32'h3FFF_C000, 32'h8000_0010, 32'h0, 1'b0, 1'b1}, // R5
        '{16'h8044, 32'h0000_0003, 32'h0000_0001, 32'h0000_0001, 32'h8000_0010, 32'h0, 1'b0, 1'b0}, // R4
        '{16'h8055, 32'h8000_0002, 32'hC000_0001, 32'hC000_0001, 32'h8000_0010, 32'h0, 1'b0, 1'b0}, // R4
        '{16'h3866, 32'h0001_0000, 32'hC000_0001, 32'hC000_0001, 32'h8000_0010, 32'h0, 1'b0, 1'b1}, // R6
        '{16'h0877, 32'h1234_5678, 32'hC000_0001, 32'hC000_0001, 32'h8000_0010, 32'h0, 1'b1, 1'b0}, // R1
        '{16'h3888, 32'h0002_0000, 32'hC000_0001, 32'hC000_0001, 32'h8000_0010, 32'h0002_0000, 1'b0, 1'b0}, // R6
        '{16'h0099, 32'h0000_0001, 32'hC000_0001, 32'hC000_0001, 32'h0000_0001, 32'h0002_0000, 1'b0, 1'b0}, // R5
        '{16'h2FFF, 32'h0001_FFFF, 32'hFFFF_8000, 32'h0000_8000, 32'h0000_0001, 32'h0002_0000, 1'b0, 1'b0}  // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    int          lat;
    bit          saw;
    logic [10:0] c_addr;
    logic        c_we;
    logic [1:0]  c_be;
    logic [31:0] c_wd;

    // Issue one instruction at a negedge; return at the negedge where done is high.
    task automatic run(input logic [15:0] ins, input logic [31:0] rd);
        mem_rdata = rd;
        while (!instr_ready) @(negedge clk);
        instr_valid = 1'b1;
        instr = ins;
        @(negedge clk);
        instr_valid = 1'b0;
        lat = 1;
        saw = 1'b0;
        while (!done && lat < 8) begin
            if (mem_req) begin
                saw = 1'b1; c_addr = mem_addr; c_we = mem_we; c_be = mem_be; c_wd = mem_wdata;
            end
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 ready", {31'd0, instr_ready}, 32'd1);
        chk("R11 flags", {28'd0, done, mem_req, err_illegal, err_format}, 32'd0);
        chk("R11 acc_re", acc_re, 32'd0);
        chk("R11 acc_im", acc_im, 32'd0);
        chk("R11 regs", param_q | repeat_q | base_q | x_q, 32'd0);

        // Table walk: R1..R6 and R10 timing
        for (int i = 0; i < 11; i++) begin
            run(VEC[i].ins, VEC[i].rd);
            chk("R10 latency", lat, VEC[i].ill ? 32'd1 : 32'd3);
            chk("R1 mem request", {31'd0, saw}, VEC[i].ill ? 32'd0 : 32'd1);
            if (saw) begin
                chk("R1 address", {21'd0, c_addr}, {21'd0, VEC[i].ins[10:0]});
                chk("R10 load no write", {31'd0, c_we}, 32'd0);
            end
            chk("R1 err_illegal", {31'd0, err_illegal}, {31'd0, VEC[i].ill});
            chk("R5 R6 err_format", {31'd0, err_format}, {31'd0, VEC[i].fmt});
            chk("R2 R3 R4 acc_re", acc_re, VEC[i].re);
            chk("R2 R3 R4 acc_im", acc_im, VEC[i].im);
            chk("R5 param", param_q, VEC[i].par);
            chk("R6 base", base_q, VEC[i].bas);
        end

        // R7: repeat load, no format check, accumulator kept
        run(16'h3001, 32'hDEAD_BEEF);
        chk("R7 repeat", repeat_q, 32'hDEAD_BEEF);
        chk("R7 acc kept", acc_re, 32'hFFFF_8000);
        chk("R7 no error", {30'd0, err_illegal, err_format}, 32'd0);

        // Load X (01000), then R8 store X (01010) at 0x7AB
        run(16'h4002, 32'h1234_ABCD);
        chk("R8 x loaded", x_q, 32'h1234_ABCD);
        run(16'h57AB, 32'h0);
        chk("R8 write", {31'd0, c_we}, 32'd1);
        chk("R8 be", {30'd0, c_be}, 32'd3);
        chk("R8 addr", {21'd0, c_addr}, 32'h7AB);
        chk("R8 wdata", c_wd, 32'h1234_ABCD);
        chk("R10 store latency", lat, 32'd3);

        // R9: store X lower (11100) at 0x012
        run(16'hE012, 32'hFFFF_FFFF);
        chk("R9 write", {31'd0, c_we}, 32'd1);
        chk("R9 be", {30'd0, c_be}, 32'd1);
        chk("R9 addr", {21'd0, c_addr}, 32'h012);
        chk("R9 wdata", c_wd, 32'h0000_ABCD);
        chk("R9 acc kept", acc_im, 32'h0000_8000);
        chk("R9 x kept", x_q, 32'h1234_ABCD);

        // R10: unknown opcode held valid while busy must be ignored
        mem_rdata = 32'h1111_1111;
        instr_valid = 1'b1;
        instr = 16'h3003;
        @(negedge clk);
        chk("R10 busy", {31'd0, instr_ready}, 32'd0);
        instr = 16'h0800;
        @(negedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R10 done", {31'd0, done}, 32'd1);
        chk("R10 busy offer ignored", {31'd0, err_illegal}, 32'd0);
        chk("R7 repeat second", repeat_q, 32'h1111_1111);
        @(negedge clk);
        chk("R10 no extra run", {30'd0, done, mem_req}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule